// File: doc/BRIEF.md
# Bit-Plane Pair Shifter

This block feeds the column shift registers of an LED matrix panel that is split into an upper half and a lower half, each with its own red, green and blue data line. Full 24-bit colour pixels arrive on a valid/ready stream, packed in a 32-bit word. The block treats consecutive pixels as pairs: the first pixel of a pair goes to the upper half and the second to the lower half. From each pixel it keeps one bit per colour channel, the bit selected by a runtime bit-plane index. It then drives six data lines and a shift clock.

A host shows an 8-bit colour frame by sending each row eight times, once per bit-plane index from 0 to 7. The row on-time for each pass doubles from one pass to the next. Each shift clock rising edge presents the previous pair's data. As a result, the first edge of a row shifts in one meaningless pair, and the host must send one extra dummy pair to push out the last real pair.

Top module: `bitplane_pair_shifter`

## Requirements
- R1: For bit-plane index p (0..7), the red bit is pixData[p], the green bit is pixData[8+p] and the blue bit is pixData[16+p]; pixData[31:24] has no effect on any output.
- R2: rgbOut bit 0/1/2 carry red/green/blue of the first (upper-half) pixel of a pair, and bits 3/4/5 carry red/green/blue of the second (lower-half) pixel.
- R3: The bit-plane index is sampled when the first pixel of a pair is accepted and is used for both pixels; a change before the second pixel has no effect on that pair.
- R4: shiftClk is low in the cycle after a first pixel is accepted and high in the cycle after a second pixel is accepted.
- R5: rgbOut takes the new pair's value one cycle after the second pixel is accepted and holds its value in all other cycles, so each shiftClk rise shows the previous pair (zeros after reset).
- R6: pixReady is low for exactly the one cycle after a second pixel is accepted and high otherwise.
- R7: While a first pixel has been taken and the second has not arrived, shiftClk stays low, rgbOut holds and pixReady stays high.
- R8: Reset (rstN low, asynchronous) drives rgbOut to 0, shiftClk low and pixReady high; the next accepted pixel is treated as a first pixel.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| planeSel | input | 3 | Bit-plane index to extract |
| pixValid | input | 1 | Pixel word valid |
| pixData | input | 32 | Pixel word: red [7:0], green [15:8], blue [23:16] |
| pixReady | output | 1 | Block can accept a pixel this cycle |
| rgbOut | output | 6 | Panel data lines, upper RGB in [2:0], lower RGB in [5:3] |
| shiftClk | output | 1 | Panel shift clock |

## Verification
A first pixel accepted at edge k sets shiftClk low after edge k. A second pixel accepted at edge k+1 sets shiftClk high and pixReady low after edge k+1. The new rgbOut value appears only after edge k+2. The bench drives inputs on falling edges and samples 1 ns after each rising edge, checking each result exactly in its due cycle. It also checks, one cycle early, that rgbOut still shows the old pair. Stall and reset cases check that the held values persist through every idle cycle.

// File: rtl/bp_shift_pkg.sv
package bpShiftPkg;
  typedef enum logic [1:0] {
    ST_EVEN = 2'd0,
    ST_ODD  = 2'd1,
    ST_EMIT = 2'd2
  } stateT;

  typedef struct packed {
    logic takeEven;
    logic takeOdd;
    logic emit;
  } strobeT;
endpackage

// File: rtl/bp_shift_ctrl.sv
module bp_shift_ctrl
  import bpShiftPkg::*;
(
  input  logic   clk,
  input  logic   rstN,
  input  logic   pixValid,
  output logic   pixReady,
  output strobeT strb,
  output stateT  state
);
  stateT nextState;

  always_comb begin
    pixReady      = (state != ST_EMIT);
    strb.takeEven = pixValid && (state == ST_EVEN);
    strb.takeOdd  = pixValid && (state == ST_ODD);
    strb.emit     = (state == ST_EMIT);
    nextState     = state;
    case (state)
      ST_EVEN: if (pixValid) nextState = ST_ODD;
      ST_ODD:  if (pixValid) nextState = ST_EMIT;
      default: nextState = ST_EVEN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_EVEN;
    else       state <= nextState;
  end
endmodule

// File: rtl/bp_shift_dp.sv
module bp_shift_dp
  import bpShiftPkg::*;
#(
  parameter int CHAN_W   = 8,
  parameter int NUM_CHAN = 3,
  localparam int PLANE_W = $clog2(CHAN_W),
  localparam int USED_W  = CHAN_W * NUM_CHAN
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  strobeT                strb,
  input  logic [PLANE_W-1:0]    planeSel,
  input  logic [USED_W-1:0]     pixBits,
  output logic [2*NUM_CHAN-1:0] rgbOut,
  output logic                  shiftClk
);
  logic [NUM_CHAN-1:0] evenSel, oddSel, evenBits, oddBits;
  logic [PLANE_W-1:0]  planeHeld;

  for (genvar c = 0; c < NUM_CHAN; c++) begin : g_chan
    logic [CHAN_W-1:0] chan;
    assign chan       = pixBits[c*CHAN_W +: CHAN_W];
    assign evenSel[c] = chan[planeSel];
    assign oddSel[c]  = chan[planeHeld];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      evenBits  <= '0;
      oddBits   <= '0;
      planeHeld <= '0;
      rgbOut    <= '0;
      shiftClk  <= 1'b0;
    end else begin
      if (strb.takeEven) begin
        evenBits  <= evenSel;
        planeHeld <= planeSel;
        shiftClk  <= 1'b0;
      end
      if (strb.takeOdd) begin
        oddBits  <= oddSel;
        shiftClk <= 1'b1;
      end
      if (strb.emit) rgbOut <= {oddBits, evenBits};
    end
  end
endmodule

// File: rtl/bitplane_pair_shifter.sv
module bitplane_pair_shifter
  import bpShiftPkg::*;
#(
  parameter int WORD_W   = 32,
  parameter int CHAN_W   = 8,
  parameter int NUM_CHAN = 3,
  localparam int PLANE_W = $clog2(CHAN_W),
  localparam int USED_W  = CHAN_W * NUM_CHAN
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [PLANE_W-1:0]    planeSel,
  input  logic                  pixValid,
  input  logic [WORD_W-1:0]     pixData,
  output logic                  pixReady,
  output logic [2*NUM_CHAN-1:0] rgbOut,
  output logic                  shiftClk
);
  strobeT strb;
  stateT  state;
  logic   unusedHi;

  assign unusedHi = ^pixData[WORD_W-1:USED_W];

  bp_shift_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pixValid(pixValid),
    .pixReady(pixReady), .strb(strb), .state(state)
  );

  bp_shift_dp #(.CHAN_W(CHAN_W), .NUM_CHAN(NUM_CHAN)) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .planeSel(planeSel),
    .pixBits(pixData[USED_W-1:0]), .rgbOut(rgbOut), .shiftClk(shiftClk)
  );
endmodule

// File: rtl/bp_shift_checker.sv
module bp_shift_checker
  import bpShiftPkg::*;
(
  input logic       clk,
  input logic       rstN,
  input logic       pixValid,
  input logic       pixReady,
  input logic [5:0] rgbOut,
  input logic       shiftClk,
  input strobeT     strb,
  input stateT      state
);
  AST_ODD_BLOCKS_READY: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeOdd |=> !pixReady); // R6
  AST_CLK_LOW_AFTER_EVEN: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeEven |=> !shiftClk); // R4
  AST_CLK_HIGH_AFTER_ODD: assert property (@(posedge clk) disable iff (!rstN)
    strb.takeOdd |=> shiftClk); // R4
  AST_OUT_ONLY_ON_EMIT: assert property (@(posedge clk) disable iff (!rstN)
    !strb.emit |=> $stable(rgbOut)); // R5
  AST_STALL_HOLDS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ODD && !pixValid) |=> ($stable(shiftClk) && pixReady)); // R7
  AST_RESET_CLEARS: assert property (@(posedge clk)
    !rstN |=> (rgbOut == 6'd0 && !shiftClk && pixReady)); // R8
endmodule

bind bitplane_pair_shifter bp_shift_checker i_chk (
  .clk(clk), .rstN(rstN), .pixValid(pixValid), .pixReady(pixReady),
  .rgbOut(rgbOut), .shiftClk(shiftClk), .strb(strb), .state(state)
);

// File: tb/test_bitplane_pair_shifter.sv
module test_bitplane_pair_shifter;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [2:0]  planeSel = '0;
  logic        pixValid = 1'b0;
  logic [31:0] pixData = '0;
  logic        pixReady;
  logic [5:0]  rgbOut;
  logic        shiftClk;
  int total = 0;
  int bad = 0;
  logic [5:0] lastOut = '0;

  always #2 clk = ~clk;

  bitplane_pair_shifter i_bitplane_pair_shifter (
    .clk(clk), .rstN(rstN), .planeSel(planeSel), .pixValid(pixValid),
    .pixData(pixData), .pixReady(pixReady), .rgbOut(rgbOut), .shiftClk(shiftClk)
  );

  // {plane, first pixel, second pixel, expected rgbOut}
  localparam logic [72:0] VEC [0:6] = '{
    {3'd0, 32'h0001_0101, 32'h0000_0000, 6'h07},
    {3'd0, 32'h0000_0000, 32'h0001_0101, 6'h38},
    {3'd7, 32'h0080_0000, 32'h0000_8000, 6'h14},
    {3'd3, 32'hFF00_0008, 32'hFF08_0000, 6'h21},
    {3'd5, 32'h00FF_FFFF, 32'h00DF_DFDF, 6'h07},
    {3'd2, 32'h0000_0404, 32'h0004_0000, 6'h23},
    {3'd6, 32'hFFBF_BFBF, 32'h0040_4040, 6'h38}
  };

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic sendPair(input logic [2:0] pEven, input logic [2:0] pOdd,
                          input logic [31:0] ev, input logic [31:0] od,
                          input logic [5:0] exp, input string tag);
    @(negedge clk); planeSel = pEven; pixData = ev; pixValid = 1'b1;
    @(posedge clk); #1;
    check(shiftClk == 1'b0, "R4 clk low after first", {31'd0, shiftClk}, 0);
    @(negedge clk); planeSel = pOdd; pixData = od;
    @(posedge clk); #1;
    check(shiftClk == 1'b1, "R4 clk high after second", {31'd0, shiftClk}, 1);
    check(pixReady == 1'b0, "R6 ready low after second", {31'd0, pixReady}, 0);
    check(rgbOut == lastOut, "R5 old pair at clock rise", {26'd0, rgbOut}, {26'd0, lastOut});
    @(negedge clk); pixValid = 1'b0;
    @(posedge clk); #1;
    check(rgbOut == exp, tag, {26'd0, rgbOut}, {26'd0, exp});
    check(pixReady == 1'b1, "R6 ready back", {31'd0, pixReady}, 1);
    lastOut = exp;
  endtask

  initial begin
    #(4 * 200000);
    bad++; total++;
    $display("FAIL watchdog actual=hang expected=finish");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    check(rgbOut == 6'd0 && !shiftClk && pixReady, "R8 reset state",
          {24'd0, pixReady, shiftClk, rgbOut}, 32'h80);
    rstN = 1'b1;

    // R1 R2 table walk
    for (int i = 0; i < 7; i++) begin
      sendPair(VEC[i][72:70], VEC[i][72:70], VEC[i][69:38], VEC[i][37:6],
               VEC[i][5:0], "R1 R2 extract and order");
    end

    // R3: index changed before second pixel has no effect
    sendPair(3'd1, 3'd4, 32'h0000_0002, 32'h0000_0002, 6'h09, "R3 plane held for pair");

    // R7: stall between first and second pixel
    @(negedge clk); planeSel = 3'd0; pixData = 32'h0000_0100; pixValid = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); pixValid = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(posedge clk); #1;
      check(!shiftClk && pixReady && rgbOut == lastOut, "R7 stall holds",
            {24'd0, pixReady, shiftClk, rgbOut}, {24'd0, 2'b10, lastOut});
    end
    @(negedge clk); pixData = 32'h0000_0000; pixValid = 1'b1;
    @(posedge clk); #1;
    check(shiftClk == 1'b1, "R7 resume clock", {31'd0, shiftClk}, 1);
    @(negedge clk); pixValid = 1'b0;
    @(posedge clk); #1;
    check(rgbOut == 6'h02, "R7 resumed pair", {26'd0, rgbOut}, 32'h02);
    lastOut = 6'h02;

    // R8: reset mid-pair, next pixel is a first pixel
    @(negedge clk); pixData = 32'h0001_0000; pixValid = 1'b1;
    @(posedge clk); #1;
    @(negedge clk); pixValid = 1'b0; rstN = 1'b0;
    @(negedge clk);
    check(rgbOut == 6'd0 && !shiftClk && pixReady, "R8 mid-pair reset",
          {24'd0, pixReady, shiftClk, rgbOut}, 32'h80);
    rstN = 1'b1;
    lastOut = 6'd0;
    sendPair(3'd0, 3'd0, 32'h0000_0001, 32'h0000_0000, 6'h01, "R8 even position after reset");

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule